// File: doc/BRIEF.md
# External Bus Chip-Select Timing Sequencer

This block produces the cycle-accurate strobe pattern for a single chip-select region of an external memory bus. A request carries a start address, a direction, a beat count, an address to switch to once the chip select drops, a flag that marks the closing access of a split transfer, and one write word. From these the sequencer drives chip select, read strobe, write strobe, the bus address and a write-data output enable. It runs either a single normal access or a page burst.

Timing comes from static configuration inputs:

- wait counts for the first beat, and separate wait counts for the later beats of a page burst;
- a strobe-assertion delay for each direction;
- a chip-select extension count for each direction;
- a write-data hold extension;
- a page-read strobe mode bit.

A beat with wait count W lasts W+1 cycles. Its last cycle is the end cycle. The strobe is active from cycle index "delay" through the end cycle.

Top module: `cs_timing_seq`

## Requirements
- R1: `req_ready` is high only when the sequencer is idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. The first access cycle, with `bus_cs_n` low, is the cycle right after.
- R2: The first beat lasts wait+1 cycles and uses the normal wait count for its direction. The strobe is low from cycle index delay up to and including the end cycle. When the delay exceeds the wait count, the strobe is low only in the end cycle.
- R3: After the end cycle of the last beat, `bus_cs_n` stays low for the read or write CS-extension count, depending on direction. A count of 0 adds no cycles. Both strobes are high during these cycles.
- R4: A single access (beat count 0 or 1) ends with exactly one cycle in which `bus_cs_n` is high and `acc_done` is high. The sequencer is idle in the cycle after.
- R5: In a page burst (beat count of 2 or more), `bus_cs_n` stays low from the first beat to the last, with no negated cycle. `acc_done` pulses in the last CS-extension cycle, or in the last end cycle when that count is 0. The sequencer is idle in the next cycle.
- R6: Beat k drives the address start + k*ADDR_STEP. Once chip select negates, the address keeps its last value if the last-access flag was set. If the flag was clear, the address becomes the next-address value, starting in the first cycle with `bus_cs_n` high.
- R7: Beats 2 and later of a page burst use the page wait count for their direction. In a page write with a nonzero write-data extension, that many cycles are added after each non-final end cycle. In those cycles `bus_cs_n` is low, `bus_wr_n` is high, `bus_wdata_oe` is high and the address is unchanged.
- R8: In the final CS extension of a write, `bus_wdata_oe` stays high for the first min(write-data extension, CS extension) cycles and is low after that.
- R9: On beats 2 and later of a page read, if `cfg_page_rd_hold` is 0, `bus_rd_n` is high in the cycles before the read delay. If it is 1, `bus_rd_n` stays low for the whole beat. The first beat always applies the delay.
- R10: `bus_wdata_oe` is high only during write accesses and never during reads or idle. `bus_wdata` carries the word captured at acceptance while the enable is high, and is zero otherwise.
- R11: During reset and immediately after it: `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are 1; `bus_wdata_oe` and `acc_done` are 0; `req_ready` is 1; the address is 0.
- R12: `bus_rd_n` and `bus_wr_n` are never low together, and neither is low while `bus_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_last | input | 1 | Last access of a split transfer |
| req_beats | input | BEAT_W | Beat count (0 and 1 = single access) |
| req_addr | input | AW | Start address |
| req_next_addr | input | AW | Address shown at CS negation when not last |
| req_wdata | input | DW | Write word |
| cfg_rd_wait | input | WAIT_W | First-beat read wait |
| cfg_wr_wait | input | WAIT_W | First-beat write wait |
| cfg_prd_wait | input | WAIT_W | Later-beat read wait |
| cfg_pwr_wait | input | WAIT_W | Later-beat write wait |
| cfg_rd_dly | input | WAIT_W | Read-strobe assertion delay |
| cfg_wr_dly | input | WAIT_W | Write-strobe assertion delay |
| cfg_rd_csx | input | EXT_W | Read CS-extension count |
| cfg_wr_csx | input | EXT_W | Write CS-extension count |
| cfg_wdx | input | EXT_W | Write-data hold extension count |
| cfg_page_rd_hold | input | 1 | Keep read strobe low on later page-read beats |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data |
| bus_wdata_oe | output | 1 | Write-data output enable |
| acc_done | output | 1 | Access-complete pulse |

## Verification
The bench builds the sequencer with a 16-bit address and data, 4-bit wait counts, 3-bit extension counts, a 3-bit beat count, an address step of 2 and data masking on.

The 4-bit waits allow a strobe delay larger than the wait count, which reaches the case where the strobe is low only in the end cycle. The 3-bit extension counts allow a write-data extension larger than the CS extension, and also a CS extension of zero. Bursts of 2 to 4 beats reach both page-read strobe modes and the write hold inserted between beats.

// File: rtl/cst_pkg.sv
`timescale 1ns/1ps
package cst_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ACC  = 3'd1,
      ST_WDX  = 3'd2,
      ST_CSX  = 3'd3,
      ST_NEG  = 3'd4
   } cst_state_e;
endpackage

// File: rtl/cst_beat_timer.sv
`timescale 1ns/1ps
// Counts cycles inside one beat and derives the strobe windows.
module cst_beat_timer #(
   parameter int WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [WAIT_W-1:0] wait_lim,
   input  logic [WAIT_W-1:0] rd_dly,
   input  logic [WAIT_W-1:0] wr_dly,
   output logic              end_cyc,
   output logic              rd_win,
   output logic              wr_win
);
   logic [WAIT_W-1:0] idx_q;

   assign end_cyc = run && (idx_q == wait_lim);
   assign rd_win  = run && ((idx_q >= rd_dly) || end_cyc);
   assign wr_win  = run && ((idx_q >= wr_dly) || end_cyc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                idx_q <= '0;
      else if (!run || end_cyc)  idx_q <= '0;
      else                       idx_q <= idx_q + 1'b1;
   end

   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (idx_q <= wait_lim)); // R2
   AST_END_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      end_cyc |-> (rd_win && wr_win)); // R2
endmodule

// File: rtl/cst_ext_timer.sv
`timescale 1ns/1ps
// Up-counter shared by the inter-beat write hold and the final CS extension.
module cst_ext_timer #(
   parameter int EXT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [EXT_W-1:0] lim,
   output logic [EXT_W-1:0] cnt,
   output logic             last_cyc
);
   logic [EXT_W-1:0] cnt_q;

   assign cnt      = cnt_q;
   assign last_cyc = run && (cnt_q == (lim - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run || last_cyc) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end

   AST_EXT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (lim != '0)); // R3
   AST_EXT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < lim)); // R3
endmodule

// File: rtl/cst_ctrl.sv
`timescale 1ns/1ps
// Phase sequencing, request capture and the address register.
module cst_ctrl import cst_pkg::*; #(
   parameter int AW        = 24,
   parameter int DW        = 16,
   parameter int WAIT_W    = 4,
   parameter int EXT_W     = 3,
   parameter int BEAT_W    = 3,
   parameter int ADDR_STEP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_last,
   input  logic [BEAT_W-1:0] req_beats,
   input  logic [AW-1:0]     req_addr,
   input  logic [AW-1:0]     req_next_addr,
   input  logic [DW-1:0]     req_wdata,
   input  logic [WAIT_W-1:0] cfg_rd_wait,
   input  logic [WAIT_W-1:0] cfg_wr_wait,
   input  logic [WAIT_W-1:0] cfg_prd_wait,
   input  logic [WAIT_W-1:0] cfg_pwr_wait,
   input  logic [EXT_W-1:0]  cfg_rd_csx,
   input  logic [EXT_W-1:0]  cfg_wr_csx,
   input  logic [EXT_W-1:0]  cfg_wdx,
   input  logic              end_cyc,
   input  logic              x_last,
   output cst_state_e        st,
   output logic              wr_q,
   output logic              later_beat,
   output logic [AW-1:0]     addr,
   output logic [DW-1:0]     wdata,
   output logic [WAIT_W-1:0] wait_sel,
   output logic [EXT_W-1:0]  ext_lim,
   output logic              done,
   output logic              ready
);
   localparam logic [AW-1:0]     STEP = AW'(ADDR_STEP);
   localparam logic [BEAT_W-1:0] ONE  = BEAT_W'(1);

   cst_state_e        st_q, st_d;
   logic              last_q;
   logic [BEAT_W-1:0] nbeat_q, bidx_q, bidx_d;
   logic [AW-1:0]     addr_q, addr_d, next_q;
   logic [DW-1:0]     data_q;
   logic              page, last_beat, accept;
   logic [EXT_W-1:0]  csx_sel;

   assign page       = (nbeat_q != ONE);
   assign last_beat  = (bidx_q == (nbeat_q - 1'b1));
   assign accept     = req_valid && (st_q == ST_IDLE);
   assign csx_sel    = wr_q ? cfg_wr_csx : cfg_rd_csx;
   assign ext_lim    = (st_q == ST_WDX) ? cfg_wdx : csx_sel;
   assign later_beat = (bidx_q != '0);
   assign st         = st_q;
   assign addr       = addr_q;
   assign wdata      = data_q;
   assign ready      = (st_q == ST_IDLE);

   always_comb begin
      if (wr_q) wait_sel = later_beat ? cfg_pwr_wait : cfg_wr_wait;
      else      wait_sel = later_beat ? cfg_prd_wait : cfg_rd_wait;
   end

   always_comb begin
      st_d   = st_q;
      addr_d = addr_q;
      bidx_d = bidx_q;
      done   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (req_valid) begin
               st_d   = ST_ACC;
               addr_d = req_addr;
               bidx_d = '0;
            end
         end
         ST_ACC: begin
            if (end_cyc) begin
               if (!last_beat) begin
                  if (wr_q && (cfg_wdx != '0)) begin
                     st_d = ST_WDX;
                  end else begin
                     addr_d = addr_q + STEP;
                     bidx_d = bidx_q + 1'b1;
                  end
               end else if (csx_sel != '0) begin
                  st_d = ST_CSX;
               end else begin
                  st_d = page ? ST_IDLE : ST_NEG;
                  done = page;
                  if (!last_q) addr_d = next_q;
               end
            end
         end
         ST_WDX: begin
            if (x_last) begin
               st_d   = ST_ACC;
               addr_d = addr_q + STEP;
               bidx_d = bidx_q + 1'b1;
            end
         end
         ST_CSX: begin
            if (x_last) begin
               st_d = page ? ST_IDLE : ST_NEG;
               done = page;
               if (!last_q) addr_d = next_q;
            end
         end
         ST_NEG: begin
            st_d = ST_IDLE;
            done = 1'b1;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         addr_q  <= '0;
         bidx_q  <= '0;
         wr_q    <= 1'b0;
         last_q  <= 1'b0;
         nbeat_q <= ONE;
         next_q  <= '0;
         data_q  <= '0;
      end else begin
         st_q   <= st_d;
         addr_q <= addr_d;
         bidx_q <= bidx_d;
         if (accept) begin
            wr_q    <= req_write;
            last_q  <= req_last;
            nbeat_q <= (req_beats == '0) ? ONE : req_beats;
            next_q  <= req_next_addr;
            data_q  <= req_wdata;
         end
      end
   end

   AST_WDX_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WDX && $past(st_q) == ST_WDX) |-> (addr_q == $past(addr_q))); // R7
   AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |-> (bidx_q < nbeat_q)); // R5
   AST_NEG_ONLY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_NEG) |-> !page); // R4
endmodule

// File: rtl/cs_timing_seq.sv
`timescale 1ns/1ps
// Chip-select timing sequencer top: wires the timers and control, forms bus pins.
module cs_timing_seq import cst_pkg::*; #(
   parameter int AW        = 24,
   parameter int DW        = 16,
   parameter int WAIT_W    = 4,
   parameter int EXT_W     = 3,
   parameter int BEAT_W    = 3,
   parameter int ADDR_STEP = 2,
   parameter bit DATA_MASK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_last,
   input  logic [BEAT_W-1:0] req_beats,
   input  logic [AW-1:0]     req_addr,
   input  logic [AW-1:0]     req_next_addr,
   input  logic [DW-1:0]     req_wdata,
   input  logic [WAIT_W-1:0] cfg_rd_wait,
   input  logic [WAIT_W-1:0] cfg_wr_wait,
   input  logic [WAIT_W-1:0] cfg_prd_wait,
   input  logic [WAIT_W-1:0] cfg_pwr_wait,
   input  logic [WAIT_W-1:0] cfg_rd_dly,
   input  logic [WAIT_W-1:0] cfg_wr_dly,
   input  logic [EXT_W-1:0]  cfg_rd_csx,
   input  logic [EXT_W-1:0]  cfg_wr_csx,
   input  logic [EXT_W-1:0]  cfg_wdx,
   input  logic              cfg_page_rd_hold,
   output logic              bus_cs_n,
   output logic              bus_rd_n,
   output logic              bus_wr_n,
   output logic [AW-1:0]     bus_addr,
   output logic [DW-1:0]     bus_wdata,
   output logic              bus_wdata_oe,
   output logic              acc_done
);
   generate
      if (AW < 2 || DW < 1) begin : g_bad_width
         $error("cs_timing_seq: address or data width too small");
      end
      if (WAIT_W < 1 || EXT_W < 1 || BEAT_W < 2) begin : g_bad_count
         $error("cs_timing_seq: counter widths too small");
      end
      if (ADDR_STEP < 1) begin : g_bad_step
         $error("cs_timing_seq: address step must be positive");
      end
   endgenerate

   cst_state_e        st;
   logic              wr_q, later_beat, end_cyc, rd_win, wr_win, x_last;
   logic              in_acc, in_cs, x_run;
   logic [AW-1:0]     addr_q;
   logic [DW-1:0]     data_q;
   logic [WAIT_W-1:0] wait_sel;
   logic [EXT_W-1:0]  ext_lim, x_cnt;

   assign in_acc = (st == ST_ACC);
   assign x_run  = (st == ST_WDX) || (st == ST_CSX);
   assign in_cs  = in_acc || x_run;

   cst_beat_timer #(.WAIT_W(WAIT_W)) u_beat (
      .clk(clk), .rst_n(rst_n), .run(in_acc), .wait_lim(wait_sel),
      .rd_dly(cfg_rd_dly), .wr_dly(cfg_wr_dly),
      .end_cyc(end_cyc), .rd_win(rd_win), .wr_win(wr_win)
   );

   cst_ext_timer #(.EXT_W(EXT_W)) u_ext (
      .clk(clk), .rst_n(rst_n), .run(x_run), .lim(ext_lim),
      .cnt(x_cnt), .last_cyc(x_last)
   );

   cst_ctrl #(
      .AW(AW), .DW(DW), .WAIT_W(WAIT_W), .EXT_W(EXT_W),
      .BEAT_W(BEAT_W), .ADDR_STEP(ADDR_STEP)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_last(req_last),
      .req_beats(req_beats), .req_addr(req_addr), .req_next_addr(req_next_addr),
      .req_wdata(req_wdata),
      .cfg_rd_wait(cfg_rd_wait), .cfg_wr_wait(cfg_wr_wait),
      .cfg_prd_wait(cfg_prd_wait), .cfg_pwr_wait(cfg_pwr_wait),
      .cfg_rd_csx(cfg_rd_csx), .cfg_wr_csx(cfg_wr_csx), .cfg_wdx(cfg_wdx),
      .end_cyc(end_cyc), .x_last(x_last),
      .st(st), .wr_q(wr_q), .later_beat(later_beat), .addr(addr_q),
      .wdata(data_q), .wait_sel(wait_sel), .ext_lim(ext_lim),
      .done(acc_done), .ready(req_ready)
   );

   assign bus_cs_n     = !in_cs;
   assign bus_rd_n     = !(in_acc && !wr_q && (rd_win || (cfg_page_rd_hold && later_beat)));
   assign bus_wr_n     = !(in_acc && wr_q && wr_win);
   assign bus_addr     = addr_q;
   assign bus_wdata_oe = wr_q && (in_acc || (st == ST_WDX) ||
                                 ((st == ST_CSX) && (x_cnt < cfg_wdx)));

   generate
      if (DATA_MASK) begin : g_mask
         assign bus_wdata = bus_wdata_oe ? data_q : '0;
      end else begin : g_raw
         assign bus_wdata = data_q;
      end
   endgenerate

   AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n); // R12
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_rd_n && !bus_wr_n)); // R12
   AST_OE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wdata_oe |-> (bus_rd_n && !bus_cs_n)); // R10
   AST_ACCEPT_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !bus_cs_n); // R1
   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> bus_cs_n); // R1
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_done |=> req_ready); // R4
endmodule

// File: tb/tb_cs_timing_seq.sv
`timescale 1ns/1ps
module tb_cs_timing_seq;
   localparam int AW = 16, DW = 16, WAIT_W = 4, EXT_W = 3, BEAT_W = 3, STEP = 2;

   typedef struct packed {
      logic cs_n, rd_n, wr_n, oe, done, rdy;
      logic [AW-1:0] addr;
      logic [DW-1:0] wd;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, req_last = 1'b0;
   logic [BEAT_W-1:0] req_beats = '0;
   logic [AW-1:0] req_addr = '0, req_next_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [WAIT_W-1:0] c_rw = 0, c_ww = 0, c_prw = 0, c_pww = 0, c_rdly = 0, c_wdly = 0;
   logic [EXT_W-1:0] c_rcsx = 0, c_wcsx = 0, c_wdx = 0;
   logic c_prh = 1'b0;
   logic req_ready, bus_cs_n, bus_rd_n, bus_wr_n, bus_wdata_oe, acc_done;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;

   int checks = 0, failures = 0;
   string tag = "R11";
   exp_t exp_q[$];

   always #2 clk = ~clk;

   cs_timing_seq #(.AW(AW), .DW(DW), .WAIT_W(WAIT_W), .EXT_W(EXT_W),
                   .BEAT_W(BEAT_W), .ADDR_STEP(STEP), .DATA_MASK(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_last(req_last), .req_beats(req_beats),
      .req_addr(req_addr), .req_next_addr(req_next_addr), .req_wdata(req_wdata),
      .cfg_rd_wait(c_rw), .cfg_wr_wait(c_ww), .cfg_prd_wait(c_prw), .cfg_pwr_wait(c_pww),
      .cfg_rd_dly(c_rdly), .cfg_wr_dly(c_wdly), .cfg_rd_csx(c_rcsx), .cfg_wr_csx(c_wcsx),
      .cfg_wdx(c_wdx), .cfg_page_rd_hold(c_prh),
      .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe), .acc_done(acc_done)
   );

   function automatic exp_t observed();
      exp_t o;
      o.cs_n = bus_cs_n; o.rd_n = bus_rd_n; o.wr_n = bus_wr_n; o.oe = bus_wdata_oe;
      o.done = acc_done; o.rdy = req_ready; o.addr = bus_addr; o.wd = bus_wdata;
      return o;
   endfunction

   task automatic compare(input exp_t e, input string t);
      exp_t o;
      o = observed();
      checks++;
      if (o !== e) begin
         failures++;
         $display("FAIL %s t=%0t act cs%b rd%b wr%b oe%b dn%b rdy%b a=%h d=%h exp cs%b rd%b wr%b oe%b dn%b rdy%b a=%h d=%h",
                  t, $time, o.cs_n, o.rd_n, o.wr_n, o.oe, o.done, o.rdy, o.addr, o.wd,
                  e.cs_n, e.rd_n, e.wr_n, e.oe, e.done, e.rdy, e.addr, e.wd);
      end
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag);
   end

   function automatic exp_t mk(input logic cs_n, rd_n, wr_n, oe, done, rdy,
                               input logic [AW-1:0] a, input logic [DW-1:0] d);
      exp_t e;
      e.cs_n = cs_n; e.rd_n = rd_n; e.wr_n = wr_n; e.oe = oe; e.done = done;
      e.rdy = rdy; e.addr = a; e.wd = oe ? d : '0;
      return e;
   endfunction

   // Driver: handshake, then push the expected per-cycle trace
   task automatic run_req(input bit wr, input int beats, input bit last,
                          input logic [AW-1:0] a, input logic [AW-1:0] nxt,
                          input logic [DW-1:0] d, input string t);
      int nb, csx, w;
      bit page, ract, wact;
      logic [AW-1:0] ba, ea;
      @(negedge clk);
      tag = t;
      req_valid = 1'b1; req_write = wr; req_last = last; req_beats = BEAT_W'(beats);
      req_addr = a; req_next_addr = nxt; req_wdata = d;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      nb   = (beats == 0) ? 1 : beats;
      page = (nb > 1);
      csx  = wr ? int'(c_wcsx) : int'(c_rcsx);
      ba   = a;
      for (int b = 0; b < nb; b++) begin
         ba = a + AW'(b * STEP);
         w  = (b == 0) ? (wr ? int'(c_ww) : int'(c_rw)) : (wr ? int'(c_pww) : int'(c_prw));
         for (int i = 0; i <= w; i++) begin
            ract = !wr && (i >= int'(c_rdly) || i == w || (c_prh && b > 0));
            wact = wr && (i >= int'(c_wdly) || i == w);
            exp_q.push_back(mk(1'b0, !ract, !wact, wr,
                               page && b == nb - 1 && i == w && csx == 0, 1'b0, ba, d));
         end
         if (b < nb - 1 && wr)
            for (int k = 0; k < int'(c_wdx); k++)
               exp_q.push_back(mk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, ba, d));
      end
      for (int k = 0; k < csx; k++)
         exp_q.push_back(mk(1'b0, 1'b1, 1'b1, wr && k < int'(c_wdx),
                            page && k == csx - 1, 1'b0, ba, d));
      ea = last ? ba : nxt;
      if (!page) exp_q.push_back(mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, ea, d));
      exp_q.push_back(mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, ea, d));
      wait (exp_q.size() == 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      compare(mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '0, '0), "R11 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare(mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '0, '0), "R11 after reset");

      c_rw = 3; c_rdly = 1; c_rcsx = 2;
      run_req(0, 1, 1, 16'h0100, 16'h0F00, 16'hAAAA, "R1 R2 R3 R4 R10 normal read");
      c_ww = 2; c_wdly = 1; c_wcsx = 3; c_wdx = 2;
      run_req(1, 0, 0, 16'h0200, 16'h0300, 16'h1234, "R6 R8 R12 normal write split");
      c_wcsx = 0; c_wdx = 3;
      run_req(1, 1, 1, 16'h0400, 16'h0500, 16'h5A5A, "R3 R8 write no CS extension");
      c_wcsx = 1; c_wdx = 4;
      run_req(1, 1, 0, 16'h0600, 16'h0700, 16'hC3C3, "R6 R8 write hold longer than CS ext");
      c_rw = 2; c_prw = 2; c_rdly = 1; c_rcsx = 1; c_prh = 0;
      run_req(0, 4, 1, 16'h1000, 16'h2000, 16'h0, "R5 R7 R9 page read strobe gaps");
      c_prh = 1;
      run_req(0, 4, 0, 16'h1100, 16'h2100, 16'h0, "R5 R6 R9 page read strobe held");
      c_ww = 2; c_pww = 1; c_wdly = 1; c_wdx = 2; c_wcsx = 2;
      run_req(1, 3, 0, 16'h3000, 16'h3800, 16'hBEEF, "R7 R8 R6 page write hold");
      c_rcsx = 0; c_prh = 0;
      run_req(0, 2, 1, 16'h4000, 16'h4800, 16'h0, "R5 page read no CS extension");
      c_rw = 1; c_rdly = 5; c_rcsx = 1;
      run_req(0, 1, 1, 16'h5000, 16'h5100, 16'h0, "R2 delay beyond wait");
      c_wdx = 0; c_pww = 0; c_ww = 1; c_wdly = 0; c_wcsx = 1;
      run_req(1, 2, 1, 16'h6000, 16'h6100, 16'h7777, "R7 R10 page write no hold");

      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule